// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Controller

This block is the control core of a synchronous burst SRAM with a 32-bit data path made of four byte lanes. Each clock it samples two address strobes, one meant for a processor and one for a memory controller, together with three chip-enable inputs, a burst-advance input, a global write input, a byte-write master enable and four per-lane write enables. From these it keeps a selected flag and an internal burst address. It then issues per-lane write strobes and a read request to a 64-word internal array.

A burst starts at the loaded address and walks through the remaining addresses of its aligned group of four, wrapping inside that group. Holding the advance input high pauses the walk, so the current address can be written or read again. The two strobes differ on the load clock. A processor-strobe load never writes, while a controller-strobe load writes at once if the write inputs ask for it. The processor strobe wins when both are low. Read data comes back one clock after the access and is driven only while output enable is low. Writes are accepted only while output enable is high.

Top module: `sburst_sram_ctrl`

## Requirements
- R1: On a clock where `proc_strobe_n` is low, no array lane is written, whatever `gw_n`, `bwe_n` and `bw_n` show. This holds also when `ctl_strobe_n` is low on the same clock, because the processor strobe has priority.
- R2: On a clock where `ctl_strobe_n` is low and `proc_strobe_n` is high, the address on `addr_i` is loaded. If the chip enables select the part, that address is written on the same clock according to R5 and R6.
- R3: On a selected clock with both strobes high and `adv_n` high, the internal address keeps its value, and any write or read goes to that address.
- R4: On a selected clock with both strobes high and `adv_n` low, the internal address first steps its two low bits by one, wrapping 3 to 0, while bits 5..2 stay fixed. The access then uses the new address, so a load at A gives the sequence A, A+1, A+2, A+3 within the aligned group.
- R5: All four lanes are written when `gw_n` is low. They are also all written when `gw_n` is high, `bwe_n` is low and `bw_n` is 4'b0000.
- R6: When `gw_n` is high and `bwe_n` is low, lane i (data bits 8i+7..8i) is written exactly when `bw_n[i]` is low, and the other lanes keep their contents. When `gw_n` and `bwe_n` are both high, nothing is written.
- R7: The part is selected by a strobe clock only when `ce_n` is low, `ce2_hi` is high and `ce2_lo_n` is low. A strobe clock with any of these inactive deselects the part. While deselected, no lane is written and `rdata_oe` stays low until a later strobe clock selects it again.
- R8: `rdata_oe` is high exactly when `oe_n` is low and the part is selected. `rdata_o` is zero whenever `rdata_oe` is low, and no lane is written on a clock where `oe_n` is low.
- R9: Read data has one clock of latency. After a selected access clock, `rdata_o` holds the array word at that clock's access address as it stood before any write on that clock.
- R10: After reset the part is deselected, `rdata_oe` is low and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Word address sampled on a strobe clock |
| proc_strobe_n | input | 1 | Processor address strobe, active low, higher priority |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2_hi | input | 1 | Chip enable, active high |
| ce2_lo_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low; high pauses the burst |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low, bit i = lane i |
| oe_n | input | 1 | Output enable, active low |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driven |
| rdata_oe | output | 1 | High while the block drives read data |

## Verification
The checker module checks several rules on every clock: the load-clock write block for the processor strobe, the freeze of the address when the burst pauses, the step-by-one-and-wrap of the low address bits with fixed upper bits, write and drive blocking while deselected or with output enable low, and a zero output when not driven. The following can only be shown by the bench's scenarios, whose behavioural model compares read data and drive enable on every clock: that the right lanes land at the right addresses, that a controller-strobe load writes at once, the priority between strobes, the chip-enable decode through each of the three inputs, and the one-clock read latency.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    // Kind of clock, decided from the strobes and the selected flag
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,  // no strobe, part deselected
        CYC_PLOAD = 2'd1,  // processor strobe load
        CYC_CLOAD = 2'd2,  // controller strobe load
        CYC_CONT  = 2'd3   // burst continuation while selected
    } cyc_e;
endpackage

// File: rtl/sbs_strobe_dec.sv
module sbs_strobe_dec
    import sbs_pkg::*;
(
    input  logic proc_strobe_n,
    input  logic ctl_strobe_n,
    input  logic ce_n,
    input  logic ce2_hi,
    input  logic ce2_lo_n,
    input  logic sel_q,
    output cyc_e cyc,
    output logic sel_next,
    output logic access
);
    logic enables_ok;

    always_comb begin
        enables_ok = !ce_n && ce2_hi && !ce2_lo_n;
        if (!proc_strobe_n) begin
            cyc = CYC_PLOAD;
        end else if (!ctl_strobe_n) begin
            cyc = CYC_CLOAD;
        end else if (sel_q) begin
            cyc = CYC_CONT;
        end else begin
            cyc = CYC_IDLE;
        end
        sel_next = (cyc == CYC_PLOAD || cyc == CYC_CLOAD) ? enables_ok : sel_q;
        access   = (cyc == CYC_CONT) ||
                   ((cyc == CYC_PLOAD || cyc == CYC_CLOAD) && enables_ok);
    end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  cyc_e              cyc,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_eff
);
    localparam logic [BURST_W-1:0] STEP = BURST_W'(1);

    logic [BURST_W-1:0] low_next;

    always_comb begin
        low_next = addr_q[BURST_W-1:0] + STEP;
        unique case (cyc)
            CYC_PLOAD, CYC_CLOAD: addr_eff = addr_i;
            CYC_CONT: begin
                if (adv_n) begin
                    addr_eff = addr_q;
                end else begin
                    addr_eff = {addr_q[ADDR_W-1:BURST_W], low_next};
                end
            end
            default: addr_eff = addr_q;
        endcase
    end
endmodule

// File: rtl/sbs_lane_qual.sv
module sbs_lane_qual
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  cyc_e             cyc,
    input  logic             sel_next,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    output logic [LANES-1:0] lane_we
);
    logic             permit;
    logic [LANES-1:0] req;

    always_comb begin
        permit = oe_n && ((cyc == CYC_CONT) || (cyc == CYC_CLOAD && sel_next));
        if (!gw_n) begin
            req = '1;
        end else if (!bwe_n) begin
            req = ~bw_n;
        end else begin
            req = '0;
        end
        lane_we = permit ? req : '0;
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         lane_we,
    input  logic                     rd_en,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    mem_q[w] <= '0;
                end
                rd_q <= '0;
            end else begin
                if (rd_en) begin
                    rd_q <= mem_q[addr];
                end
                if (lane_we[l]) begin
                    mem_q[addr] <= wdata[l*LANE_W +: LANE_W];
                end
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sburst_sram_ctrl.sv
module sburst_sram_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    proc_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    ce_n,
    input  logic                    ce2_hi,
    input  logic                    ce2_lo_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rdata_oe
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t              st_d, st_q;
    cyc_e                cyc;
    logic                sel_next;
    logic                access;
    logic [ADDR_W-1:0]   addr_eff;
    logic [LANES-1:0]    lane_we;
    logic [DATA_W-1:0]   arr_rdata;

    sbs_strobe_dec u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctl_strobe_n  (ctl_strobe_n),
        .ce_n          (ce_n),
        .ce2_hi        (ce2_hi),
        .ce2_lo_n      (ce2_lo_n),
        .sel_q         (st_q.sel),
        .cyc           (cyc),
        .sel_next      (sel_next),
        .access        (access)
    );

    sbs_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
        .cyc      (cyc),
        .adv_n    (adv_n),
        .addr_i   (addr_i),
        .addr_q   (st_q.addr),
        .addr_eff (addr_eff)
    );

    sbs_lane_qual #(.LANES(LANES)) u_qual (
        .cyc      (cyc),
        .sel_next (sel_next),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .oe_n     (oe_n),
        .lane_we  (lane_we)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr_eff),
        .lane_we (lane_we),
        .rd_en   (access),
        .wdata   (wdata_i),
        .rdata   (arr_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_next;
        if (cyc != CYC_IDLE) begin
            st_d.addr = addr_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_oe = !oe_n && st_q.sel;
        rdata_o  = rdata_oe ? arr_rdata : '0;
    end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 4,
    parameter int DATA_W  = 32,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strobe_n,
    input logic              ctl_strobe_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              sel_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [LANES-1:0]  lane_we,
    input logic              rdata_oe,
    input logic [DATA_W-1:0] rdata_o
);
    logic cont;
    logic [BURST_W-1:0] low_plus;

    assign cont     = proc_strobe_n && ctl_strobe_n && sel_q;
    assign low_plus = addr_q[BURST_W-1:0] + BURST_W'(1);

    // R1: processor-strobe load never writes
    a_r1_no_write_on_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_strobe_n |-> lane_we == '0);

    // R3: paused burst keeps its address
    a_r3_hold_on_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && adv_n) |=> addr_q == $past(addr_q));

    // R4: advance steps the low bits and wraps
    a_r4_step_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !adv_n) |=> addr_q[BURST_W-1:0] == $past(low_plus));

    // R4: upper bits fixed during a burst
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        cont |=> addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W]));

    // R7: deselected part writes nothing without a strobe
    a_r7_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && proc_strobe_n && ctl_strobe_n) |-> lane_we == '0);

    // R7: deselected part does not drive
    a_r7_desel_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !rdata_oe);

    // R8: output enable low blocks writes
    a_r8_no_write_when_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> lane_we == '0);

    // R8: undriven output is zero
    a_r8_zero_when_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> rdata_o == '0);
endmodule

bind sburst_sram_ctrl sbs_checker #(
    .ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(LANES*LANE_W), .BURST_W(BURST_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctl_strobe_n  (ctl_strobe_n),
    .adv_n         (adv_n),
    .oe_n          (oe_n),
    .sel_q         (st_q.sel),
    .addr_q        (st_q.addr),
    .lane_we       (lane_we),
    .rdata_oe      (rdata_oe),
    .rdata_o       (rdata_o)
);

// File: tb/tb_sburst_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sburst_sram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr_i = '0;
    logic        proc_strobe_n = 1'b1, ctl_strobe_n = 1'b1;
    logic        ce_n = 1'b0, ce2_hi = 1'b1, ce2_lo_n = 1'b0;
    logic        adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        rdata_oe;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sburst_sram_ctrl dut (.*);

    // behavioural reference model
    logic [31:0] m_mem [64];
    bit          m_sel;
    int          m_addr;
    logic [31:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            m_sel = 0; m_addr = 0; m_rd = '0;
        end else begin
            bit ok, wr_ok, acc;
            int ea;
            logic [3:0] lanes;
            ok = !ce_n && ce2_hi && !ce2_lo_n;
            wr_ok = 0; acc = 0; ea = m_addr;
            if (!proc_strobe_n) begin
                m_sel = ok; ea = addr_i; m_addr = ea; acc = ok;
            end else if (!ctl_strobe_n) begin
                m_sel = ok; ea = addr_i; m_addr = ea; acc = ok; wr_ok = ok;
            end else if (m_sel) begin
                if (!adv_n) ea = (m_addr / 4) * 4 + ((m_addr + 1) % 4);
                m_addr = ea; acc = 1; wr_ok = 1;
            end
            if (!gw_n) lanes = 4'hF;
            else if (!bwe_n) lanes = ~bw_n;
            else lanes = 4'h0;
            if (!oe_n) wr_ok = 0;
            if (acc) m_rd = m_mem[ea];
            if (wr_ok)
                for (int l = 0; l < 4; l++)
                    if (lanes[l]) m_mem[ea][l*8 +: 8] = wdata_i[l*8 +: 8];
        end
    end

    task automatic compare(input string tag);
        logic        e_oe;
        logic [31:0] e_d;
        e_oe = !oe_n && m_sel;
        e_d  = e_oe ? m_rd : 32'h0;
        n_cmp++;
        if (rdata_oe !== e_oe || rdata_o !== e_d) begin
            n_bad++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                     tag, rdata_oe, rdata_o, e_oe, e_d);
        end
    endtask

    // one clock: drive at current time (away from edge), then compare after the edge
    task automatic step(input bit p, input bit c, input bit adv, input bit oe,
                        input bit gw, input bit bwe, input logic [3:0] bw,
                        input logic [5:0] a, input logic [31:0] d, input string tag);
        proc_strobe_n = p; ctl_strobe_n = c; adv_n = adv; oe_n = oe;
        gw_n = gw; bwe_n = bwe; bw_n = bw; addr_i = a; wdata_i = d;
        @(posedge clk); #2;
        compare(tag);
        @(negedge clk);
    endtask

    // read burst from a: processor load, then three advances, then a final pause
    task automatic read_burst(input logic [5:0] a, input string tag);
        step(0, 1, 1, 0, 1, 1, 4'hF, a, 0, tag);
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 1, 1, 4'hF, 0, 0, tag);
        step(1, 1, 1, 0, 1, 1, 4'hF, 0, 0, tag);
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #20; @(negedge clk); rst_n = 1'b1;
        // R10: reset state, read of a fresh word returns zero
        #1; compare("R10");
        read_burst(6'd20, "R10");

        // R2 + R5 (gw_n low) + R4: controller load writes at once, then advance
        step(1, 0, 1, 1, 0, 1, 4'hF, 6'd8, 32'h11111111, "R2");
        step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'h22222222, "R4");
        step(1, 1, 0, 1, 1, 0, 4'h0, 0, 32'h33333333, "R5");
        step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'h44444444, "R4");
        read_burst(6'd8, "R4");

        // R4 wrap: load at 14, advance through 15, 12, 13 writing
        step(1, 0, 1, 1, 0, 1, 4'hF, 6'd14, 32'hA0A0A0A0, "R4");
        step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'hA1A1A1A1, "R4");
        step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'hA2A2A2A2, "R4");
        step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'hA3A3A3A3, "R4");
        read_burst(6'd12, "R4");
        read_burst(6'd16, "R4");

        // R1: processor load with gw_n low writes nothing; R3: paused cycle writes loaded address
        step(0, 1, 1, 1, 0, 1, 4'hF, 6'd32, 32'hDEADBEEF, "R1");
        step(1, 1, 1, 1, 0, 1, 4'hF, 0, 32'hCAFEF00D, "R3");
        step(1, 1, 1, 1, 1, 0, 4'h0, 0, 32'h5A5A5A5A, "R3");
        step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'h01020304, "R3");
        read_burst(6'd32, "R3");

        // R1 priority: both strobes low, write inputs active, no write at 36
        step(0, 0, 1, 1, 0, 1, 4'hF, 6'd36, 32'hFFFFFFFF, "R1");
        read_burst(6'd36, "R1");

        // R6: byte writes with several lane patterns at 40..43
        step(1, 0, 1, 1, 0, 1, 4'hF, 6'd40, 32'h00000000, "R6");
        step(1, 1, 1, 1, 1, 0, 4'b1110, 0, 32'h111111AA, "R6");
        step(1, 1, 1, 1, 1, 0, 4'b0101, 0, 32'hBB22CC33, "R6");
        step(1, 1, 0, 1, 1, 1, 4'h0, 0, 32'h99999999, "R6");
        step(1, 1, 1, 1, 1, 0, 4'b1001, 0, 32'h77DDEE77, "R6");
        step(1, 1, 0, 1, 1, 0, 4'b0111, 0, 32'hF0000000, "R6");
        read_burst(6'd40, "R6");

        // R8: oe_n low during write request blocks the write
        step(1, 0, 1, 0, 0, 1, 4'hF, 6'd44, 32'h12345678, "R8");
        step(1, 1, 1, 0, 1, 0, 4'h0, 0, 32'h12345678, "R8");
        step(1, 1, 1, 1, 1, 1, 4'hF, 0, 0, "R8");
        read_burst(6'd44, "R8");

        // R7: each chip enable deselects on a strobe; writes and drive blocked
        for (int e = 0; e < 3; e++) begin
            ce_n = (e == 0); ce2_hi = (e != 1); ce2_lo_n = (e == 2);
            step(1, 0, 1, 1, 0, 1, 4'hF, 6'd48, 32'hBAD00000 + e, "R7");
            ce_n = 1'b0; ce2_hi = 1'b1; ce2_lo_n = 1'b0;
            step(1, 1, 0, 1, 0, 1, 4'hF, 0, 32'hBAD10000 + e, "R7");
            step(1, 1, 0, 0, 0, 1, 4'hF, 0, 0, "R7");
        end
        // R7: reselect by strobe and confirm nothing reached 48..51
        read_burst(6'd48, "R7");

        // R9: write then immediate read shows old word on load, new one after
        step(1, 0, 1, 1, 0, 1, 4'hF, 6'd60, 32'hC0FFEE00, "R9");
        step(1, 1, 1, 0, 1, 1, 4'hF, 0, 0, "R9");
        step(1, 1, 1, 0, 1, 1, 4'hF, 0, 0, "R9");
        step(1, 1, 1, 1, 0, 1, 4'hF, 0, 32'h0BADCAFE, "R9");
        step(1, 1, 1, 0, 1, 1, 4'hF, 0, 0, "R9");
        step(1, 1, 1, 0, 1, 1, 4'hF, 0, 0, "R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule